// File: doc/BRIEF.md
# Graphic LCD Cursor and Clear Sequencer

This block tracks the graphic cursor of a dot-matrix display built from several 64-column controller chips. It turns host operations into a stream of command and data byte transfers for a downstream bus interface. The cursor is an X column that runs across all chips and a Y page. The block does not generate bus timing and does not select chips. It hands each transfer, together with the current column, to the bus interface, which drives the pins.

The host presents one operation at a time over a request/acknowledge handshake. The four operations are:

- **Cursor placement:** sets the column and page on the display.
- **Data write:** writes one byte at the cursor, then advances the column. When the advance crosses into the next chip, the block sends that chip a fresh column address.
- **Clear:** writes zero bytes over every column of every page, then returns the cursor home.
- **Power-up init:** waits a settle time, turns the display on, and then runs a clear.

Every transfer on the bus side waits for its own acknowledge.

Top module: `glcd_cursor_seq`

## Requirements
- R1: After reset, `busy`, `bus_req` and `host_ack` are low, and the cursor reads column 0, page 0.
- R2: A cursor operation (`host_op` = 0) loads `host_x` and `host_y`. It then sends two commands: first 0x40 OR the low 6 bits of the column, then 0xB8 OR the page.
- R3: A write operation (`host_op` = 1) sends `host_data` as a data transfer, with `bus_x` equal to the column before the write. Once that transfer is acknowledged, the column advances by one, modulo the full column range, and the page is unchanged.
- R4: If that advance leaves the low 6 bits of the column at zero, the next transfer is command 0x40, with `bus_x` set to the new column. This covers the wrap from the last column to column 0.
- R5: A clear (`host_op` = 2) visits pages 0 to PAGES-1 in order. For each page it sends the column-0 and page commands, then writes 0x00 to every column, and each chip crossing inserts the R4 command.
- R6: After the last page, a clear sends command 0xC0 and then the cursor commands for column 0, page 0. The cursor then reads 0,0.
- R7: An init (`host_op` = 3) pulses `unmask_chips` in its accept cycle. The bus then stays idle for exactly WAIT_CYCLES clock cycles, after which the block sends command 0x3F and then the full R5/R6 clear.
- R8: `host_ack` is asserted only while the block is idle. `busy` rises on the edge that accepts an operation and falls on the edge that completes that operation's last bus transfer.
- R9: A bus transfer holds `bus_req`, `bus_is_data`, `bus_byte` and `bus_x` steady until `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host operation request |
| host_op | input | 2 | 0 cursor, 1 write, 2 clear, 3 init |
| host_x | input | X_W | Column for a cursor operation |
| host_y | input | Y_W | Page for a cursor operation |
| host_data | input | 8 | Byte for a write operation |
| host_ack | output | 1 | Operation accepted this cycle |
| busy | output | 1 | Operation in progress |
| unmask_chips | output | 1 | One-cycle pulse telling the bus interface to re-enable all chips |
| cur_x | output | X_W | Current column |
| cur_y | output | Y_W | Current page |
| bus_req | output | 1 | Transfer request to the bus interface |
| bus_is_data | output | 1 | 1 data transfer, 0 command |
| bus_byte | output | 8 | Byte to transfer |
| bus_x | output | X_W | Column at transfer time, used for chip selection |
| bus_ack | input | 1 | Transfer completed |

## Verification
The bench uses the default geometry: four chips and eight pages, which gives a 256-column cursor and a full 2,099-transfer clear. These defaults make reachable the wrap from column 255 back to 0 and the last-page exit of the clear loop. WAIT_CYCLES is reduced to 40, so the init settle window can be measured to the exact cycle while a complete init-plus-clear still fits well inside the run.

// File: rtl/glcd_seq_pkg.sv
package glcd_seq_pkg;
  localparam int unsigned COLW = 6;
  localparam logic [7:0] CMD_COL_BASE  = 8'h40;
  localparam logic [7:0] CMD_PAGE_BASE = 8'hB8;
  localparam logic [7:0] CMD_DISP_ON   = 8'h3F;
  localparam logic [7:0] CMD_START_LN  = 8'hC0;

  typedef enum logic [1:0] {
    OP_CURSOR = 2'd0,
    OP_WRITE  = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_INIT   = 2'd3
  } op_e;

  function automatic logic [7:0] col_cmd(input logic [COLW-1:0] col);
    return CMD_COL_BASE | {2'b00, col};
  endfunction

  function automatic logic [7:0] page_cmd(input logic [2:0] page);
    return CMD_PAGE_BASE | {5'b00000, page};
  endfunction
endpackage

// File: rtl/glcd_cursor.sv
module glcd_cursor #(
  parameter int unsigned X_W   = 8,
  parameter int unsigned Y_W   = 3,
  parameter int unsigned PAGES = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [X_W-1:0] load_x,
  input  logic [Y_W-1:0] load_y,
  input  logic           step_x,
  input  logic           step_y,
  output logic [X_W-1:0] x,
  output logic [Y_W-1:0] y,
  output logic           edge_next,
  output logic           x_zero,
  output logic           y_last
);
  import glcd_seq_pkg::*;

  assign edge_next = (x[COLW-1:0] == {COLW{1'b1}});
  assign x_zero    = (x == '0);
  assign y_last    = (y == Y_W'(PAGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (load) begin
      x <= load_x;
      y <= load_y;
    end else begin
      if (step_x) x <= x + 1'b1;
      if (step_y) y <= y + 1'b1;
    end
  end
endmodule

// File: rtl/glcd_wait.sv
module glcd_wait #(
  parameter int unsigned CYCLES = 6250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/glcd_seq_fsm.sv
module glcd_seq_fsm #(
  parameter int unsigned X_W = 8,
  parameter int unsigned Y_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_req,
  input  logic [1:0]     host_op,
  input  logic [X_W-1:0] host_x,
  input  logic [Y_W-1:0] host_y,
  input  logic [7:0]     host_data,
  output logic           host_ack,
  output logic           busy,
  output logic           unmask_chips,
  input  logic [X_W-1:0] x,
  input  logic [Y_W-1:0] y,
  input  logic           edge_next,
  input  logic           x_zero,
  input  logic           y_last,
  output logic           cur_load,
  output logic [X_W-1:0] cur_load_x,
  output logic [Y_W-1:0] cur_load_y,
  output logic           cur_step_x,
  output logic           cur_step_y,
  output logic           wait_run,
  input  logic           wait_done,
  output logic           bus_req,
  output logic           bus_is_data,
  output logic [7:0]     bus_byte,
  input  logic           bus_ack
);
  import glcd_seq_pkg::*;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_ON, S_COL, S_PAGE, S_DATA, S_WRAP, S_START
  } state_e;
  typedef enum logic [1:0] {C_SET, C_WR, C_CLR, C_HOME} ctx_e;

  state_e     st;
  ctx_e       ctx;
  logic [7:0] wdata;
  op_e        op;
  logic       accept;
  logic       xfer_done;

  assign op        = op_e'(host_op);
  assign accept    = host_req && (st == S_IDLE);
  assign host_ack  = accept;
  assign busy      = (st != S_IDLE);
  assign unmask_chips = accept && (op == OP_INIT);
  assign wait_run  = (st == S_WAIT);
  assign bus_req   = (st != S_IDLE) && (st != S_WAIT);
  assign xfer_done = bus_req && bus_ack;
  assign bus_is_data = (st == S_DATA);

  always_comb begin
    case (st)
      S_ON:    bus_byte = CMD_DISP_ON;
      S_COL:   bus_byte = col_cmd(x[COLW-1:0]);
      S_PAGE:  bus_byte = page_cmd(3'(y));
      S_DATA:  bus_byte = (ctx == C_CLR) ? 8'h00 : wdata;
      S_WRAP:  bus_byte = CMD_COL_BASE;
      S_START: bus_byte = CMD_START_LN;
      default: bus_byte = 8'h00;
    endcase
  end

  // cursor control: loads on accept (cursor/clear) and at init/home points
  always_comb begin
    cur_load   = (accept && (op == OP_CURSOR || op == OP_CLEAR)) ||
                 (xfer_done && (st == S_ON || st == S_START));
    cur_load_x = (accept && op == OP_CURSOR) ? host_x : '0;
    cur_load_y = (accept && op == OP_CURSOR) ? host_y : '0;
    cur_step_x = xfer_done && (st == S_DATA);
    cur_step_y = xfer_done && (st == S_WRAP) && (ctx == C_CLR) && x_zero && !y_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ctx   <= C_SET;
      wdata <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          case (op)
            OP_CURSOR: begin st <= S_COL;  ctx <= C_SET; end
            OP_WRITE:  begin st <= S_DATA; ctx <= C_WR; wdata <= host_data; end
            OP_CLEAR:  begin st <= S_COL;  ctx <= C_CLR; end
            default:   begin st <= S_WAIT; ctx <= C_CLR; end
          endcase
        end
        S_WAIT:  if (wait_done) st <= S_ON;
        S_ON:    if (xfer_done) st <= S_COL;
        S_COL:   if (xfer_done) st <= S_PAGE;
        S_PAGE:  if (xfer_done) st <= (ctx == C_CLR) ? S_DATA : S_IDLE;
        S_DATA:  if (xfer_done) begin
          if (edge_next)          st <= S_WRAP;
          else if (ctx == C_WR)   st <= S_IDLE;
        end
        S_WRAP:  if (xfer_done) begin
          if (ctx == C_WR)        st <= S_IDLE;
          else if (!x_zero)       st <= S_DATA;
          else if (y_last)        st <= S_START;
          else                    st <= S_COL;
        end
        S_START: if (xfer_done) begin st <= S_COL; ctx <= C_HOME; end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_byte) && $stable(bus_is_data))) else $error("hold"); // R9
  AST_BUSY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> busy) else $error("busy"); // R8
  AST_INIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_chips |=> !bus_req) else $error("init quiet"); // R7
endmodule

// File: rtl/glcd_cursor_seq.sv
module glcd_cursor_seq #(
  parameter int unsigned CHIPS       = 4,
  parameter int unsigned PAGES       = 8,
  parameter int unsigned WAIT_CYCLES = 6250000,
  localparam int unsigned X_W        = glcd_seq_pkg::COLW + $clog2(CHIPS),
  localparam int unsigned Y_W        = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_req,
  input  logic [1:0]     host_op,
  input  logic [X_W-1:0] host_x,
  input  logic [Y_W-1:0] host_y,
  input  logic [7:0]     host_data,
  output logic           host_ack,
  output logic           busy,
  output logic           unmask_chips,
  output logic [X_W-1:0] cur_x,
  output logic [Y_W-1:0] cur_y,
  output logic           bus_req,
  output logic           bus_is_data,
  output logic [7:0]     bus_byte,
  output logic [X_W-1:0] bus_x,
  input  logic           bus_ack
);
  import glcd_seq_pkg::*;

  logic           cur_load, cur_step_x, cur_step_y;
  logic [X_W-1:0] cur_load_x;
  logic [Y_W-1:0] cur_load_y;
  logic           edge_next, x_zero, y_last;
  logic           wait_run, wait_done;

  glcd_cursor #(.X_W(X_W), .Y_W(Y_W), .PAGES(PAGES)) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .load(cur_load), .load_x(cur_load_x), .load_y(cur_load_y),
    .step_x(cur_step_x), .step_y(cur_step_y),
    .x(cur_x), .y(cur_y),
    .edge_next(edge_next), .x_zero(x_zero), .y_last(y_last)
  );

  glcd_wait #(.CYCLES(WAIT_CYCLES)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(wait_run), .done(wait_done)
  );

  glcd_seq_fsm #(.X_W(X_W), .Y_W(Y_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_op(host_op), .host_x(host_x), .host_y(host_y),
    .host_data(host_data), .host_ack(host_ack), .busy(busy),
    .unmask_chips(unmask_chips),
    .x(cur_x), .y(cur_y), .edge_next(edge_next), .x_zero(x_zero), .y_last(y_last),
    .cur_load(cur_load), .cur_load_x(cur_load_x), .cur_load_y(cur_load_y),
    .cur_step_x(cur_step_x), .cur_step_y(cur_step_y),
    .wait_run(wait_run), .wait_done(wait_done),
    .bus_req(bus_req), .bus_is_data(bus_is_data), .bus_byte(bus_byte),
    .bus_ack(bus_ack)
  );

  assign bus_x = cur_x;

  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_is_data && bus_ack) |=> (cur_x == $past(cur_x) + 1'b1) && $stable(cur_y)) else $error("step"); // R3
  AST_CHIP_EDGE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_is_data && bus_ack && cur_x[COLW-1:0] == {COLW{1'b1}})
      |=> (bus_req && !bus_is_data && bus_byte == CMD_COL_BASE)) else $error("edge"); // R4
  AST_START_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_is_data && bus_byte == CMD_START_LN && bus_ack)
      |=> (cur_x == '0 && cur_y == '0)) else $error("home"); // R6
  AST_PAGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_is_data && bus_byte[7:3] == 5'b10111)
      |-> (bus_byte[2:0] == 3'(cur_y))) else $error("page"); // R2
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !host_ack) else $error("ack busy"); // R8
endmodule

// File: tb/glcd_cursor_seq_test.sv
`timescale 1ns/1ps
module glcd_cursor_seq_test;
  localparam int W = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_req = 1'b0;
  logic [1:0] host_op = 2'd0;
  logic [7:0] host_x = 8'd0;
  logic [2:0] host_y = 3'd0;
  logic [7:0] host_data = 8'd0;
  logic       host_ack, busy, unmask_chips, bus_req, bus_is_data;
  logic [7:0] cur_x, bus_x, bus_byte;
  logic [2:0] cur_y;
  logic       bus_ack = 1'b0;

  glcd_cursor_seq #(.CHIPS(4), .PAGES(8), .WAIT_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_op(host_op),
    .host_x(host_x), .host_y(host_y), .host_data(host_data),
    .host_ack(host_ack), .busy(busy), .unmask_chips(unmask_chips),
    .cur_x(cur_x), .cur_y(cur_y), .bus_req(bus_req), .bus_is_data(bus_is_data),
    .bus_byte(bus_byte), .bus_x(bus_x), .bus_ack(bus_ack)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [16:0] expq [4096];
  logic [16:0] gotq [4096];
  int en = 0, gn = 0;
  int mx = 0, my = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] col_byte(input int x); return 8'(64 + (x % 64)); endfunction
  function automatic logic [7:0] page_byte(input int y); return 8'(184 + y); endfunction

  task automatic push(input bit d, input logic [7:0] b, input int x);
    expq[en] = {d, b, 8'(x)};
    en++;
  endtask
  task automatic m_cursor(input int x, input int y);
    mx = x; my = y;
    push(0, col_byte(mx), mx);
    push(0, page_byte(my), mx);
  endtask
  task automatic m_write(input logic [7:0] d);
    push(1, d, mx);
    mx = (mx + 1) % 256;
    if (mx % 64 == 0) push(0, 8'h40, mx);   // R4 chip crossing
  endtask
  task automatic m_clear();
    for (int p = 0; p < 8; p++) begin
      m_cursor(0, p);
      for (int c = 0; c < 256; c++) m_write(8'h00);
    end
    push(0, 8'hC0, mx);
    m_cursor(0, 0);
  endtask

  // bus responder: random acknowledge latency, R9 field stability
  initial begin
    logic [16:0] snap;
    bit pend;
    int dly;
    pend = 0; dly = 0; snap = '0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        pend = 0;
      end else if (bus_req) begin
        if (!pend) begin
          pend = 1;
          snap = {bus_is_data, bus_byte, bus_x};
          dly = $urandom_range(0, 2);
        end else begin
          chk(snap == {bus_is_data, bus_byte, bus_x}, "R9 held fields", int'({bus_is_data, bus_byte, bus_x}), int'(snap));
        end
        if (dly == 0) begin
          bus_ack = 1'b1;
          if (gn < 4096) gotq[gn] = {bus_is_data, bus_byte, bus_x};
          gn++;
        end else dly--;
      end
    end
  end

  task automatic run_op(input int op, input int x, input int y, input logic [7:0] d, input string tag);
    int k, first_req;
    en = 0; gn = 0;
    case (op)
      0: m_cursor(x, y);
      1: m_write(d);
      2: m_clear();
      default: begin push(0, 8'h3F, mx); m_clear(); end
    endcase
    @(posedge clk); #1;
    host_req = 1'b1; host_op = 2'(op); host_x = 8'(x); host_y = 3'(y); host_data = d;
    @(negedge clk);
    chk(host_ack == 1'b1, "R8 ack when idle", int'(host_ack), 1);
    chk(unmask_chips == (op == 3), "R7 unmask pulse", int'(unmask_chips), int'(op == 3));
    @(posedge clk); #1;
    host_req = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    k = 0; first_req = -1;
    forever begin
      @(posedge clk); #1;
      k++;
      if (first_req < 0 && bus_req) first_req = k;
      if (op >= 2 && k == 5) begin
        host_req = 1'b1; host_op = 2'd1; #1;
        chk(host_ack == 1'b0, "R8 no ack while busy", int'(host_ack), 0);
      end
      if (op >= 2 && k == 9) host_req = 1'b0;
      if (!busy) break;
    end
    chk(bus_ack == 1'b1, "R8 busy falls on final ack", int'(bus_ack), 1);
    if (op == 3) chk(first_req == W, "R7 settle window", first_req, W);
    chk(gn == en, {tag, " transfer count"}, gn, en);
    for (int i = 0; i < en && i < gn; i++)
      chk(gotq[i] == expq[i], {tag, " transfer"}, int'(gotq[i]), int'(expq[i]));
    chk(cur_x == 8'(mx), {tag, " cursor x"}, int'(cur_x), mx);
    chk(cur_y == 3'(my), {tag, " cursor y"}, int'(cur_y), my);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(busy == 0, "R1 reset busy", int'(busy), 0);
    chk(bus_req == 0, "R1 reset bus_req", int'(bus_req), 0);
    chk(host_ack == 0, "R1 reset host_ack", int'(host_ack), 0);
    chk(cur_x == 0 && cur_y == 0, "R1 reset cursor", int'(cur_x), 0);

    run_op(3, 0, 0, 8'h00, "R7 init+R5/R6 clear");
    // directed corners
    run_op(0, 137, 5, 8'h00, "R2 cursor");
    run_op(0, 63, 2, 8'h00, "R2 cursor");
    run_op(1, 0, 0, 8'hA5, "R3/R4 write 63->64");
    run_op(0, 255, 7, 8'h00, "R2 cursor");
    run_op(1, 0, 0, 8'h5A, "R3/R4 write 255->0");
    run_op(1, 0, 0, 8'hFF, "R3 write");
    // constrained random mix
    for (int n = 0; n < 250; n++) begin
      if ($urandom_range(0, 9) < 3)
        run_op(0, $urandom_range(0, 255), $urandom_range(0, 7), 8'h00, "R2 cursor");
      else
        run_op(1, 0, 0, 8'($urandom_range(0, 255)), "R3/R4 write");
    end
    run_op(0, 200, 3, 8'h00, "R2 cursor");
    run_op(2, 0, 0, 8'h00, "R5/R6 clear");
    run_op(1, 0, 0, 8'h3C, "R3 write after clear");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule